// File: doc/BRIEF.md
# Dependence-Chain Issue Steering

This block sits after register renaming. It places each incoming instruction into one of several in-order issue queues so that a chain of dependent instructions ends up in the same queue. Wakeup and selection then look only at the oldest entry of each queue, not at a whole window. A per-register availability bit records which values exist. Each queue keeps the destination register of its youngest entry. Every incoming source operand is compared with these tail destinations to find the queue to join.

Instructions arrive one per cycle as a destination and two source register numbers. When an instruction is accepted, its destination is marked unavailable. A completion pulse carrying a register number marks that register available again. A queue head issues once both of its sources are available, and at most one head issues per cycle.

Top module: `chain_steer`

## Requirements
- R1: After reset every queue is empty, every register is available, `in_ready` is 1 and `issue_valid` is 0. An instruction accepted into an idle block with available sources appears at the issue port in the next cycle, from queue 0.
- R2: Accepting an instruction marks its destination register unavailable from the next cycle on. A later instruction that reads that register does not issue before the matching completion.
- R3: A completion pulse for a register makes it available at the next clock edge. A queue head waiting only on that register shows `issue_valid` in the cycle right after the pulse.
- R4: If the first source is unavailable and equals the tail destination of a non-full, non-empty queue, the instruction is appended to that queue.
- R5: If only the second source matches a tail in this way, the instruction is appended to that queue. If both sources match tails, the first source's queue is chosen.
- R6: If no source matches a tail, the instruction goes to the lowest-numbered empty queue. This covers both available sources and a producer that already has a successor behind it.
- R7: If no tail matches and no queue is empty, `in_ready` is 0 and the offered instruction is not accepted while it stays low.
- R8: Only queue heads are considered for issue. An entry whose sources are available does not issue while an older entry of its queue is waiting.
- R9: When several heads can issue in one cycle, the lowest-numbered queue issues first, one per cycle. `issue_queue`, `issue_dst`, `issue_src_a` and `issue_src_b` describe the issuing entry, and it leaves its queue at the next clock edge.
- R10: A matching tail in a full queue is not eligible. Such an instruction is steered as if no tail had matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_dst | input | REG_W | Destination register of the offered instruction |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_ready | output | 1 | The offered instruction has a queue and is taken at the edge |
| done_valid | input | 1 | Completion pulse |
| done_reg | input | REG_W | Register whose value became available |
| issue_valid | output | 1 | A queue head issues this cycle |
| issue_queue | output | QW | Index of the issuing queue |
| issue_dst | output | REG_W | Destination of the issuing entry |
| issue_src_a | output | REG_W | First source of the issuing entry |
| issue_src_b | output | REG_W | Second source of the issuing entry |

## Verification
The assertions assume the inputs come from a renamer:
- No destination number is reused while a producer of it is still in flight.
- A completion names a register that is pending.
- No completion names the register being steered in the same cycle.

Under these assumptions at most one queue tail matches any source, and queue overflow is ruled out by the steering choice alone. The stimulus gives every in-flight instruction its own destination and pulses each completion once, always for a register that a steered instruction wrote. Registers 0 and 2 serve as permanently available sources.

// File: rtl/chain_steer_pkg.sv
package chain_steer_pkg;

  typedef enum logic [1:0] {
    PICK_STALL   = 2'd0,
    PICK_CHAIN_A = 2'd1,
    PICK_CHAIN_B = 2'd2,
    PICK_FRESH   = 2'd3
  } pick_e;

  // Index of the lowest set bit; zero when the vector is empty.
  function automatic int unsigned lowest_index(input logic [31:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ready_table.sv
module ready_table #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_reg,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_reg,
  output logic [NUM_REGS-1:0] ready_bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_bits <= '1;
    end else begin
      if (set_en) ready_bits[set_reg] <= 1'b1;
      if (clr_en) ready_bits[clr_reg] <= 1'b0;
    end
  end

  AST_CLEAR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !ready_bits[$past(clr_reg)]); // R2

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_reg == set_reg)) |=> ready_bits[$past(set_reg)]); // R3

endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [REG_W-1:0] push_dst,
  input  logic [REG_W-1:0] push_src_a,
  input  logic [REG_W-1:0] push_src_b,
  input  logic             pop,
  output logic [REG_W-1:0] head_dst,
  output logic [REG_W-1:0] head_src_a,
  output logic [REG_W-1:0] head_src_b,
  output logic             empty,
  output logic             full,
  output logic [REG_W-1:0] tail_dst
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [REG_W-1:0] dst_mem [DEPTH];
  logic [REG_W-1:0] a_mem   [DEPTH];
  logic [REG_W-1:0] b_mem   [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty      = (count == '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign head_dst   = dst_mem[rd_ptr];
  assign head_src_a = a_mem[rd_ptr];
  assign head_src_b = b_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      dst_mem[wr_ptr] <= push_dst;
      a_mem[wr_ptr]   <= push_src_a;
      b_mem[wr_ptr]   <= push_src_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      tail_dst <= '0;
    end else begin
      if (push) begin
        wr_ptr   <= step(wr_ptr);
        tail_dst <= push_dst;
      end
      if (pop) rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full)); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty)); // R9

  AST_TAIL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (tail_dst == $past(push_dst)) && !empty); // R4

endmodule

// File: rtl/steer_pick.sv
module steer_pick
  import chain_steer_pkg::*;
#(
  parameter int NUM_Q    = 8,
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5
) (
  input  logic [NUM_REGS-1:0] ready_bits,
  input  logic [REG_W-1:0]    src_a,
  input  logic [REG_W-1:0]    src_b,
  input  logic [REG_W-1:0]    tail_dst [NUM_Q],
  input  logic [NUM_Q-1:0]    q_empty,
  input  logic [NUM_Q-1:0]    q_full,
  output pick_e               pick,
  output logic [NUM_Q-1:0]    target
);

  logic             a_pending, b_pending;
  logic [NUM_Q-1:0] match_a, match_b;

  function automatic logic [NUM_Q-1:0] first_of(input logic [NUM_Q-1:0] v);
    return v & (~v + NUM_Q'(1));
  endfunction

  assign a_pending = !ready_bits[src_a];
  assign b_pending = !ready_bits[src_b];

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      match_a[q] = a_pending && !q_empty[q] && !q_full[q] && (tail_dst[q] == src_a);
      match_b[q] = b_pending && !q_empty[q] && !q_full[q] && (tail_dst[q] == src_b);
    end
  end

  always_comb begin
    if (|match_a) begin
      pick   = PICK_CHAIN_A;
      target = first_of(match_a);
    end else if (|match_b) begin
      pick   = PICK_CHAIN_B;
      target = first_of(match_b);
    end else if (|q_empty) begin
      pick   = PICK_FRESH;
      target = first_of(q_empty);
    end else begin
      pick   = PICK_STALL;
      target = '0;
    end
  end

endmodule

// File: rtl/chain_steer.sv
module chain_steer
  import chain_steer_pkg::*;
#(
  parameter int NUM_Q    = 8,
  parameter int Q_DEPTH  = 8,
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int QW       = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  output logic             in_ready,
  input  logic             done_valid,
  input  logic [REG_W-1:0] done_reg,
  output logic             issue_valid,
  output logic [QW-1:0]    issue_queue,
  output logic [REG_W-1:0] issue_dst,
  output logic [REG_W-1:0] issue_src_a,
  output logic [REG_W-1:0] issue_src_b
);

  logic [NUM_REGS-1:0] ready_bits;
  logic [NUM_Q-1:0]    q_empty, q_full, target, push_vec, head_ready, grant;
  logic [REG_W-1:0]    tail_dst [NUM_Q];
  logic [REG_W-1:0]    head_dst [NUM_Q];
  logic [REG_W-1:0]    head_a   [NUM_Q];
  logic [REG_W-1:0]    head_b   [NUM_Q];
  pick_e               pick;
  logic                accept;

  ready_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (done_valid),
    .set_reg    (done_reg),
    .clr_en     (accept),
    .clr_reg    (in_dst),
    .ready_bits (ready_bits)
  );

  steer_pick #(.NUM_Q(NUM_Q), .NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_pick (
    .ready_bits (ready_bits),
    .src_a      (in_src_a),
    .src_b      (in_src_b),
    .tail_dst   (tail_dst),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .pick       (pick),
    .target     (target)
  );

  assign in_ready = (pick != PICK_STALL);
  assign accept   = in_valid && in_ready;
  assign push_vec = accept ? target : '0;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    chain_fifo #(.DEPTH(Q_DEPTH), .REG_W(REG_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push_vec[q]),
      .push_dst   (in_dst),
      .push_src_a (in_src_a),
      .push_src_b (in_src_b),
      .pop        (grant[q]),
      .head_dst   (head_dst[q]),
      .head_src_a (head_a[q]),
      .head_src_b (head_b[q]),
      .empty      (q_empty[q]),
      .full       (q_full[q]),
      .tail_dst   (tail_dst[q])
    );
    assign head_ready[q] = !q_empty[q] && ready_bits[head_a[q]] && ready_bits[head_b[q]];
  end

  assign grant       = head_ready & (~head_ready + NUM_Q'(1));
  assign issue_valid = |head_ready;
  assign issue_queue = QW'(lowest_index(32'(head_ready)));
  assign issue_dst   = head_dst[issue_queue];
  assign issue_src_a = head_a[issue_queue];
  assign issue_src_b = head_b[issue_queue];

  AST_STALL_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (q_empty == '0)); // R7

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (ready_bits[issue_src_a] && ready_bits[issue_src_b])); // R8

  AST_ONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (issue_valid == (grant != '0))); // R9

endmodule

// File: tb/chain_steer_test.sv
`timescale 1ns/1ps
module chain_steer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, done_valid;
  logic [4:0] in_dst, in_src_a, in_src_b, done_reg;
  logic       in_ready, issue_valid;
  logic [2:0] issue_queue;
  logic [4:0] issue_dst, issue_src_a, issue_src_b;

  always #2.5 clk = ~clk;

  chain_steer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_ready(in_ready),
    .done_valid(done_valid), .done_reg(done_reg), .issue_valid(issue_valid),
    .issue_queue(issue_queue), .issue_dst(issue_dst),
    .issue_src_a(issue_src_a), .issue_src_b(issue_src_b)
  );

  int checks = 0;
  int fails  = 0;
  int log_n  = 0;
  int log_q [64];
  int log_d [64];

  // Table walk: {dst, src_a, src_b} per cycle, back to back.
  localparam logic [14:0] STEER_VEC [10] = '{
    {5'd1,  5'd0, 5'd0}, {5'd3,  5'd1, 5'd2}, {5'd4, 5'd3, 5'd2},
    {5'd5,  5'd4, 5'd2}, {5'd6,  5'd4, 5'd2}, {5'd7, 5'd6, 5'd2},
    {5'd8,  5'd5, 5'd2}, {5'd9,  5'd1, 5'd2}, {5'd10, 5'd2, 5'd8},
    {5'd11, 5'd7, 5'd10}
  };
  localparam logic [4:0] DONE_VEC [8] = '{5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd8, 5'd7, 5'd10};
  // Expected issue order: {queue, dst}.
  localparam logic [7:0] ISSUE_VEC [10] = '{
    {3'd0, 5'd1}, {3'd0, 5'd3}, {3'd2, 5'd9}, {3'd0, 5'd4}, {3'd0, 5'd5},
    {3'd1, 5'd6}, {3'd0, 5'd8}, {3'd1, 5'd7}, {3'd0, 5'd10}, {3'd1, 5'd11}
  };

  always @(negedge clk) begin
    if (rst_n && issue_valid && log_n < 64) begin
      log_q[log_n] = issue_queue;
      log_d[log_n] = issue_dst;
      log_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; done_valid = 1'b0;
    in_dst = '0; in_src_a = '0; in_src_b = '0; done_reg = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    log_n = 0;
  endtask

  task automatic steer(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b, input string tag);
    in_dst = d; in_src_a = a; in_src_b = b; in_valid = 1'b1;
    #1;
    check(in_ready == 1'b1, tag, in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic complete(input logic [4:0] r);
    done_valid = 1'b1; done_reg = r;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic check_log(input int idx, input int q, input int d, input string tag);
    check(log_n > idx && log_q[idx] == q, tag, log_q[idx], q);
    check(log_n > idx && log_d[idx] == d, tag, log_d[idx], d);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R1: reset state and first issue
    #1;
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(issue_valid == 1'b0, "R1 issue_valid after reset", issue_valid, 0);
    @(negedge clk);
    steer(5'd5, 5'd6, 5'd7, "R1 accept");
    #1;
    check(issue_valid == 1'b1, "R1 issue next cycle", issue_valid, 1);
    check(issue_queue == 3'd0, "R9 issue_queue", issue_queue, 0);
    check(issue_dst == 5'd5, "R9 issue_dst", issue_dst, 5);
    check(issue_src_a == 5'd6 && issue_src_b == 5'd7, "R9 issue sources",
          {issue_src_a, issue_src_b}, {5'd6, 5'd7});

    // Table walk: R4 R5 R6 R9 steering and wake order
    do_reset();
    for (int i = 0; i < 10; i++)
      steer(STEER_VEC[i][14:10], STEER_VEC[i][9:5], STEER_VEC[i][4:0], "R4 R5 R6 table accept");
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      complete(DONE_VEC[i]);
      repeat (4) @(negedge clk);
    end
    check(log_n == 10, "R4 R5 R6 table issue count", log_n, 10);
    for (int i = 0; i < 10; i++)
      check_log(i, int'(ISSUE_VEC[i][7:5]), int'(ISSUE_VEC[i][4:0]), "R4 R5 R6 R9 table order");

    // R2 / R3: destination pending until completion, wake one cycle later
    do_reset();
    steer(5'd20, 5'd0, 5'd0, "R2 accept producer");
    repeat (3) @(negedge clk);
    steer(5'd21, 5'd20, 5'd0, "R2 accept consumer");
    repeat (4) @(negedge clk);
    #1;
    check(log_n == 1, "R2 consumer held", log_n, 1);
    complete(5'd20);
    #1;
    check(log_n == 2, "R3 wake next cycle", log_n, 2);
    check_log(1, 0, 21, "R3 woken entry");

    // R8: ready entry behind a waiting head stays put
    do_reset();
    steer(5'd1, 5'd0, 5'd0, "R8 accept root");
    repeat (3) @(negedge clk);
    steer(5'd10, 5'd1, 5'd0, "R8 accept head");
    steer(5'd12, 5'd10, 5'd0, "R8 accept follower");
    complete(5'd10);
    repeat (3) @(negedge clk);
    #1;
    check(log_n == 1, "R8 follower blocked", log_n, 1);
    complete(5'd1);
    repeat (3) @(negedge clk);
    check_log(1, 0, 10, "R8 head first");
    check_log(2, 0, 12, "R8 follower after");

    // R7: every queue busy with no matching tail
    do_reset();
    steer(5'd1, 5'd0, 5'd0, "R7 accept root");
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++)
      steer(5'(10 + i), 5'd1, 5'd1, "R6 fill fresh");
    in_valid = 1'b0; in_dst = 5'd20; in_src_a = 5'd17; in_src_b = 5'd0;
    #1;
    check(in_ready == 1'b1, "R4 tail match while all busy", in_ready, 1);
    in_src_a = 5'd1; in_src_b = 5'd1;
    #1;
    check(in_ready == 1'b0, "R7 stall", in_ready, 0);
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    complete(5'd1);
    repeat (12) @(negedge clk);
    check(log_n == 9, "R7 stalled instruction not taken", log_n, 9);
    for (int i = 1; i < 9; i++)
      check_log(i, i - 1, 9 + i, "R9 lowest queue first");

    // R10: matching tail in a full queue is skipped
    do_reset();
    steer(5'd1, 5'd0, 5'd0, "R10 accept root");
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++)
      steer(5'(10 + i), (i == 0) ? 5'd1 : 5'(9 + i), 5'd0, "R4 fill chain");
    steer(5'd18, 5'd17, 5'd0, "R10 accept past full");
    complete(5'd17);
    repeat (3) @(negedge clk);
    check(log_n == 2, "R10 issue count", log_n, 2);
    check_log(1, 1, 18, "R10 placed in fresh queue");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule